// File: doc/BRIEF.md
# Context Configuration Loader

This block feeds configuration contexts into a processing array made of reconfigurable cells. Every cell keeps two configuration layers. One layer drives the datapath while the other is being filled. When a start command arrives with a base address, the loader reads a fixed-length context from a synchronous context memory, one word per cycle. It decodes each word into exactly one write: either to a cell configuration register or to a global constant register. Cell writes always go into the shadow layer, so the array can keep executing from the active layer while the next context is loaded.

When a complete shadow context is present, the loader swaps layers. If the array is idle, the swap happens at once. Otherwise it happens in the same cycle the array reports completion, so there is no reload gap. If the array finishes before the shadow load is done, the array stays idle and the swap waits for the last word. If the array finishes and no next context is loaded or loading, the block pulses an interrupt to the host. A start that arrives while the shadow side is busy or occupied is rejected, and a sticky error bit is raised.

Top module: `ctx_cfg_loader`

## Requirements
- R1: After reset, `layer_sel_o`, `run_o`, `shadow_valid_o`, `err_o`, `irq_o`, `mem_rd_o`, `cfg_we_o` and `grf_we_o` are all 0.
- R2: An accepted start issues exactly 128 reads, one per cycle, in the cycles right after the accepting edge. The addresses are base, base+1, ..., base+127, wrapping modulo 2^ADDR_W. The memory returns data one cycle after `mem_rd_o`.
- R3: Every word read produces exactly one write, two cycles after its read. If bit 31 is 0, the write is a cell write (`cfg_we_o`) with row = bits [30:28] and column = bits [27:25]. If bit 31 is 1, the write is a global register write (`grf_we_o`) with index = bits [27:25]. In both cases the payload `cfg_data_o` = bits [24:0].
- R4: Cell writes target the layer opposite to `layer_sel_o`, and `layer_sel_o` does not change while a write is presented.
- R5: `shadow_valid_o` rises in the cycle after the 128th write, which is 131 cycles after the accepting edge. It clears when the layers swap.
- R6: With `run_o` low, the swap occurs at the edge that ends the first cycle with `shadow_valid_o` high. After that edge, `layer_sel_o` has toggled, `run_o` = 1 and `shadow_valid_o` = 0.
- R7: While `run_o` is high, a new context loads without disturbing `layer_sel_o`. `done_i` with `shadow_valid_o` high swaps at that same edge, and `run_o` stays high.
- R8: `done_i` during a shadow load drops `run_o`, holds `layer_sel_o` until the load completes, and then swaps as in R6. No interrupt is raised.
- R9: `done_i` with `run_o` high, no shadow context and no load in progress drops `run_o` and pulses `irq_o` for exactly one cycle, in the cycle after `done_i`.
- R10: `done_i` while `run_o` is low has no effect: no interrupt, no layer change, no writes.
- R11: `start_i` while a load is in progress or `shadow_valid_o` is high is rejected. It causes no extra reads, and the current load continues unchanged. It sets `err_o`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load request for the next context |
| start_base_i | input | ADDR_W | Context base word address |
| done_i | input | 1 | Array finished the active context |
| mem_rd_o | output | 1 | Context memory read strobe |
| mem_addr_o | output | ADDR_W | Context memory word address |
| mem_data_i | input | 32 | Context word, one cycle after the read |
| cfg_we_o | output | 1 | Cell configuration write |
| cfg_layer_o | output | 1 | Layer targeted by the cell write |
| cfg_row_o | output | ROW_W | Cell row |
| cfg_col_o | output | COL_W | Cell column |
| grf_we_o | output | 1 | Global register write |
| grf_idx_o | output | GRF_W | Global register index |
| cfg_data_o | output | 31-ROW_W-COL_W | Write payload |
| layer_sel_o | output | 1 | Layer driving the datapath |
| run_o | output | 1 | Array holds an active context to execute |
| shadow_valid_o | output | 1 | Shadow layer holds a complete context |
| irq_o | output | 1 | Task-finished interrupt pulse |
| err_o | output | 1 | Sticky rejected-start flag |

## Verification
A stuck or skipped word counter shows up on the read address bus in the very next cycle. It also shifts the write stream, so a field or payload mismatches two cycles later. A wrong shadow-valid or run state shows as a swap that comes a cycle early, late or not at all. It can also show as a missing or spurious interrupt in the cycle after `done_i`. Every context sweep therefore compares all 128 writes field by field, and checks the layer, run and interrupt state in the exact cycle each should change.

// File: rtl/ctx_cfg_pkg.sv
`timescale 1ns/1ps
package ctx_cfg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned KIND_BIT = WORD_W - 1;

  typedef enum logic {
    TGT_CELL = 1'b0,
    TGT_GRF  = 1'b1
  } tgt_e;
endpackage

// File: rtl/ctx_fetch.sv
`timescale 1ns/1ps
module ctx_fetch #(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTX_WORDS = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = (CTX_WORDS > 1) ? $clog2(CTX_WORDS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CTX_WORDS - 1);

  logic              act_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      base_q <= '0;
    end else if (go_i) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      base_q <= base_i;
    end else if (act_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) act_q <= 1'b0;
    end
  end

  assign rd_o   = act_q;
  assign addr_o = base_q + ADDR_W'(cnt_q);
  assign last_o = act_q && (cnt_q == CNT_LAST);

  AST_RD_CONTIGUOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && $past(rd_o) && !$past(go_i)) |-> (addr_o == ADDR_W'($past(addr_o) + 1'b1))); // R2
  AST_STOP_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !go_i) |=> !rd_o); // R2
endmodule

// File: rtl/ctx_decode.sv
`timescale 1ns/1ps
module ctx_decode
  import ctx_cfg_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 3,
  parameter int unsigned GRF_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              last_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              cell_we_o,
  output logic              grf_we_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic [GRF_W-1:0]  grf_o,
  output logic [WORD_W-ROW_W-COL_W-2:0] data_o,
  output logic              last_o,
  output logic              busy_o
);
  localparam int unsigned IDX_W = ROW_W + COL_W;
  localparam int unsigned PAY_W = WORD_W - 1 - IDX_W;

  logic             rv_q, rl_q;
  logic             cell_we_q, grf_we_q, last_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [GRF_W-1:0] grf_q;
  logic [PAY_W-1:0] data_q;
  tgt_e             kind;

  assign kind = tgt_e'(word_i[KIND_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q      <= 1'b0;
      rl_q      <= 1'b0;
      cell_we_q <= 1'b0;
      grf_we_q  <= 1'b0;
      last_q    <= 1'b0;
      row_q     <= '0;
      col_q     <= '0;
      grf_q     <= '0;
      data_q    <= '0;
    end else begin
      rv_q      <= rd_i;
      rl_q      <= rd_i && last_i;
      cell_we_q <= rv_q && (kind == TGT_CELL);
      grf_we_q  <= rv_q && (kind == TGT_GRF);
      last_q    <= rv_q && rl_q;
      if (rv_q) begin
        row_q  <= word_i[PAY_W+COL_W +: ROW_W];
        col_q  <= word_i[PAY_W +: COL_W];
        grf_q  <= word_i[PAY_W +: GRF_W];
        data_q <= word_i[PAY_W-1:0];
      end
    end
  end

  assign cell_we_o = cell_we_q;
  assign grf_we_o  = grf_we_q;
  assign row_o     = row_q;
  assign col_o     = col_q;
  assign grf_o     = grf_q;
  assign data_o    = data_q;
  assign last_o    = last_q;
  assign busy_o    = rv_q | cell_we_q | grf_we_q;

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cell_we_q, grf_we_q})); // R3
  AST_WRITE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_we_q || grf_we_q) |-> $past(rd_i, 2)); // R3
endmodule

// File: rtl/ctx_layer_ctrl.sv
`timescale 1ns/1ps
module ctx_layer_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_busy_i,
  input  logic wr_last_i,
  input  logic done_i,
  output logic start_ok_o,
  output logic layer_o,
  output logic run_o,
  output logic shadow_valid_o,
  output logic irq_o,
  output logic err_o
);
  logic layer_q, run_q, shadow_q, irq_q, err_q;
  logic swap;

  assign start_ok_o = start_i && !load_busy_i && !shadow_q;
  // swap in the finishing cycle itself when the next context is ready
  assign swap = shadow_q && (!run_q || done_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      layer_q  <= 1'b0;
      run_q    <= 1'b0;
      shadow_q <= 1'b0;
      irq_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_last_i)  shadow_q <= 1'b1;
      else if (swap)  shadow_q <= 1'b0;
      if (swap)        layer_q <= ~layer_q;
      if (swap)        run_q   <= 1'b1;
      else if (done_i) run_q   <= 1'b0;
      irq_q <= done_i && run_q && !shadow_q && !load_busy_i;
      if (start_i && !start_ok_o) err_q <= 1'b1;
    end
  end

  assign layer_o        = layer_q;
  assign run_o          = run_q;
  assign shadow_valid_o = shadow_q;
  assign irq_o          = irq_q;
  assign err_o          = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R11
  AST_SWAP_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (layer_q != $past(layer_q)) |-> ($past(shadow_q) && !shadow_q && run_q)); // R6
  AST_HOLD_WHILE_LOADING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_busy_i |=> (layer_q == $past(layer_q))); // R8
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q); // R9
endmodule

// File: rtl/ctx_cfg_loader.sv
`timescale 1ns/1ps
module ctx_cfg_loader
  import ctx_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned CTX_WORDS = 128,
  parameter int unsigned ROW_W     = 3,
  parameter int unsigned COL_W     = 3,
  parameter int unsigned GRF_W     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_base_i,
  input  logic              done_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  output logic              cfg_we_o,
  output logic              cfg_layer_o,
  output logic [ROW_W-1:0]  cfg_row_o,
  output logic [COL_W-1:0]  cfg_col_o,
  output logic              grf_we_o,
  output logic [GRF_W-1:0]  grf_idx_o,
  output logic [WORD_W-ROW_W-COL_W-2:0] cfg_data_o,
  output logic              layer_sel_o,
  output logic              run_o,
  output logic              shadow_valid_o,
  output logic              irq_o,
  output logic              err_o
);
  logic start_ok, rd, rd_last, dec_last, dec_busy, fetch_busy;
  logic layer;

  ctx_fetch #(.ADDR_W(ADDR_W), .CTX_WORDS(CTX_WORDS)) u_fetch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (start_ok),
    .base_i (start_base_i),
    .rd_o   (rd),
    .addr_o (mem_addr_o),
    .last_o (rd_last)
  );

  ctx_decode #(.ROW_W(ROW_W), .COL_W(COL_W), .GRF_W(GRF_W)) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd),
    .last_i    (rd_last),
    .word_i    (mem_data_i),
    .cell_we_o (cfg_we_o),
    .grf_we_o  (grf_we_o),
    .row_o     (cfg_row_o),
    .col_o     (cfg_col_o),
    .grf_o     (grf_idx_o),
    .data_o    (cfg_data_o),
    .last_o    (dec_last),
    .busy_o    (dec_busy)
  );

  assign fetch_busy = rd;

  ctx_layer_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start_i),
    .load_busy_i    (fetch_busy | dec_busy),
    .wr_last_i      (dec_last),
    .done_i         (done_i),
    .start_ok_o     (start_ok),
    .layer_o        (layer),
    .run_o          (run_o),
    .shadow_valid_o (shadow_valid_o),
    .irq_o          (irq_o),
    .err_o          (err_o)
  );

  assign mem_rd_o    = rd;
  assign layer_sel_o = layer;
  assign cfg_layer_o = ~layer;

  AST_LAYER_STABLE_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_o || grf_we_o) |-> $stable(layer_sel_o)); // R4
  AST_NO_READ_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadow_valid_o |-> !mem_rd_o); // R11
endmodule

// File: tb/ctx_cfg_loader_test.sv
`timescale 1ns/1ps
module ctx_cfg_loader_test;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          start_i;
  logic [AW-1:0] start_base_i;
  logic          done_i;
  logic          mem_rd_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_data_i;
  logic          cfg_we_o, cfg_layer_o, grf_we_o;
  logic [2:0]    cfg_row_o, cfg_col_o, grf_idx_o;
  logic [24:0]   cfg_data_o;
  logic          layer_sel_o, run_o, shadow_valid_o, irq_o, err_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [AW-1:0] exp_base;
  int            rd_k, wr_k;
  logic          exp_wlayer;
  logic          rd_h1, rd_h2;

  always #2 clk = ~clk;

  ctx_cfg_loader uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_base_i(start_base_i),
    .done_i(done_i), .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .cfg_we_o(cfg_we_o), .cfg_layer_o(cfg_layer_o), .cfg_row_o(cfg_row_o),
    .cfg_col_o(cfg_col_o), .grf_we_o(grf_we_o), .grf_idx_o(grf_idx_o),
    .cfg_data_o(cfg_data_o), .layer_sel_o(layer_sel_o), .run_o(run_o),
    .shadow_valid_o(shadow_valid_o), .irq_o(irq_o), .err_o(err_o)
  );

  function automatic logic [31:0] word_f(input logic [AW-1:0] a);
    logic [5:0] idx;
    idx = 6'(a[5:0] * 6'd3);
    return {a[2] ^ a[5], idx, a ^ 10'h2AA, a[7:0], ~a[6:0]};
  endfunction

  // synchronous context memory, one-cycle read latency
  always @(posedge clk) if (mem_rd_o) mem_data_i <= word_f(mem_addr_o);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // stream monitor: addresses, write latency and decoded fields
  always @(negedge clk) begin
    if (rst_ni === 1'b1) begin
      if (mem_rd_o) begin
        chk(rd_k < 128 && mem_addr_o == AW'(exp_base + AW'(rd_k)), "R2 read address",
            64'(mem_addr_o), 64'(AW'(exp_base + AW'(rd_k))));
        rd_k++;
      end
      if (cfg_we_o || grf_we_o) begin
        logic [31:0] w;
        w = word_f(AW'(exp_base + AW'(wr_k)));
        chk(rd_h2 && wr_k < 128, "R3 write timing", 64'(wr_k), 64'(rd_k));
        if (!w[31]) begin
          chk(cfg_we_o && !grf_we_o && cfg_row_o == w[30:28] && cfg_col_o == w[27:25] &&
              cfg_data_o == w[24:0], "R3 cell write",
              {cfg_we_o, grf_we_o, cfg_row_o, cfg_col_o, cfg_data_o},
              {2'b10, w[30:25], w[24:0]});
          chk(cfg_layer_o == exp_wlayer, "R4 shadow layer", 64'(cfg_layer_o), 64'(exp_wlayer));
        end else begin
          chk(grf_we_o && !cfg_we_o && grf_idx_o == w[27:25] && cfg_data_o == w[24:0],
              "R3 global register write", {cfg_we_o, grf_we_o, grf_idx_o, cfg_data_o},
              {2'b01, w[27:25], w[24:0]});
        end
        wr_k++;
      end
      rd_h2 = rd_h1;
      rd_h1 = mem_rd_o;
    end else begin
      rd_h1 = 1'b0;
      rd_h2 = 1'b0;
    end
  end

  task automatic start_ctx(input logic [AW-1:0] b, input logic l);
    @(posedge clk); #1;
    exp_base = b; rd_k = 0; wr_k = 0; exp_wlayer = l;
    start_i = 1'b1; start_base_i = b;
    @(posedge clk); #1;
    start_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(posedge clk); #1 done_i = 1'b1;
    @(posedge clk); #1 done_i = 1'b0;
  endtask

  task automatic stray_start(input logic [AW-1:0] b);
    @(posedge clk); #1 start_i = 1'b1; start_base_i = b;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic wait_shadow(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!shadow_valid_o && n < 400);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #80000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1 actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    rst_ni = 1'b0; start_i = 1'b0; start_base_i = '0; done_i = 1'b0;
    exp_base = '0; rd_k = 128; wr_k = 128; exp_wlayer = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({layer_sel_o, run_o, shadow_valid_o, err_o, irq_o, mem_rd_o, cfg_we_o, grf_we_o} == 8'h00,
        "R1 reset state", {layer_sel_o, run_o, shadow_valid_o, err_o, irq_o, mem_rd_o, cfg_we_o, grf_we_o}, 0);
    @(posedge clk); #1 rst_ni = 1'b1;

    // first context into idle array
    start_ctx(10'h010, 1'b1);
    wait_shadow(n);
    chk(n == 131, "R5 shadow valid timing", 64'(n), 131);
    chk(layer_sel_o == 1'b0 && run_o == 1'b0, "R6 no swap before full", {layer_sel_o, run_o}, 0);
    @(negedge clk);
    chk({layer_sel_o, run_o, shadow_valid_o} == 3'b110, "R6 swap when idle",
        {layer_sel_o, run_o, shadow_valid_o}, 3'b110);
    chk(rd_k == 128 && wr_k == 128, "R2 burst length", {32'(rd_k), 32'(wr_k)}, {32'd128, 32'd128});

    // second context behind execution, with a rejected start mid-load
    start_ctx(10'h200, 1'b0);
    repeat (19) @(posedge clk);
    stray_start(10'h000);
    @(negedge clk);
    chk(err_o == 1'b1, "R11 reject during load", 64'(err_o), 1);
    wait_shadow(n);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(layer_sel_o == 1'b1 && shadow_valid_o && run_o, "R7 hold while running",
          {layer_sel_o, shadow_valid_o, run_o}, 3'b111);
    end
    pulse_done();
    @(negedge clk);
    chk({layer_sel_o, run_o, shadow_valid_o, irq_o} == 4'b0100, "R7 swap on done",
        {layer_sel_o, run_o, shadow_valid_o, irq_o}, 4'b0100);
    chk(rd_k == 128 && wr_k == 128, "R11 load unchanged", {32'(rd_k), 32'(wr_k)}, {32'd128, 32'd128});

    // third context wraps the address space, done arrives early
    start_ctx(10'h3F0, 1'b1);
    repeat (29) @(posedge clk);
    pulse_done();
    @(negedge clk);
    chk({layer_sel_o, run_o, irq_o} == 3'b000, "R8 early done holds layer",
        {layer_sel_o, run_o, irq_o}, 0);
    wait_shadow(n);
    chk(layer_sel_o == 1'b0, "R8 layer held until full", 64'(layer_sel_o), 0);
    @(negedge clk);
    chk({layer_sel_o, run_o, shadow_valid_o} == 3'b110, "R8 deferred swap",
        {layer_sel_o, run_o, shadow_valid_o}, 3'b110);
    chk(rd_k == 128 && wr_k == 128, "R2 wrapped burst", {32'(rd_k), 32'(wr_k)}, {32'd128, 32'd128});

    // task finished with nothing queued
    pulse_done();
    @(negedge clk);
    chk(irq_o == 1'b1 && run_o == 1'b0, "R9 interrupt", {irq_o, run_o}, 2'b10);
    @(negedge clk);
    chk(irq_o == 1'b0, "R9 single pulse", 64'(irq_o), 0);

    // done while idle
    pulse_done();
    @(negedge clk);
    chk({irq_o, run_o, layer_sel_o} == 3'b001, "R10 idle done ignored", {irq_o, run_o, layer_sel_o}, 3'b001);
    repeat (3) @(negedge clk);
    chk(irq_o == 1'b0 && wr_k == 128 && rd_k == 128, "R10 no activity", {irq_o, 32'(wr_k)}, {1'b0, 32'd128});

    // reject while shadow occupied
    @(posedge clk); #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    chk(err_o == 1'b0 && layer_sel_o == 1'b0, "R1 error cleared by reset", {err_o, layer_sel_o}, 0);
    start_ctx(10'h080, 1'b1);
    wait_shadow(n);
    @(negedge clk);
    chk(layer_sel_o && run_o, "R6 swap after reset", {layer_sel_o, run_o}, 2'b11);
    start_ctx(10'h100, 1'b0);
    wait_shadow(n);
    stray_start(10'h040);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(shadow_valid_o && !mem_rd_o && rd_k == 128, "R11 reject while shadow full",
          {shadow_valid_o, mem_rd_o, 32'(rd_k)}, {2'b10, 32'd128});
    end
    chk(err_o == 1'b1, "R11 sticky error", 64'(err_o), 1);
    pulse_done();
    @(negedge clk);
    chk({layer_sel_o, run_o, err_o} == 3'b011, "R7 swap keeps error", {layer_sel_o, run_o, err_o}, 3'b011);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule